// File: doc/BRIEF.md
# Validated SDRAM Mode Register

This block holds the operating settings of a synchronous DRAM: the CAS latency, whether bursts step through addresses sequentially or interleaved, the read burst length and the write burst length. A separate command decoder raises `cmdValid` for one cycle when a mode-set command is accepted. Bank tracking logic supplies `banksIdle`. The new settings arrive on the 12-bit address word.

The block checks the sampled word against the legal encodings. Two reserved bits must be zero, and the two top bits are don't-care. Bit 9 decides whether writes use the programmed burst length or a single beat. A legal word, presented while both banks are idle, replaces all settings on the next clock edge. Any other command leaves the settings exactly as they were and raises `rejectPulse` for one cycle.

Top module: `sdram_mode_guard`

## Requirements
- R1: After reset the outputs are CAS latency 3, sequential burst type (`burstInterleave` = 0), read burst length 1, write burst length 1, and `rejectPulse` low.
- R2: When `cmdValid` and `banksIdle` are high and the word is legal, the outputs from the next cycle on are as follows. `casLatency` equals bits [6:4]. `burstInterleave` equals bit 3. `readBurstLen` equals 1, 2, 4 or 8 for codes 000, 001, 010 and 011 in bits [2:0].
- R3: A burst length code of 100 to 111 in bits [2:0] makes the word illegal, and all settings are kept.
- R4: A CAS latency code of 000 or 100 to 111 in bits [6:4] makes the word illegal, and all settings are kept.
- R5: A one in bit 7 or in bit 8 makes the word illegal, and all settings are kept.
- R6: Bits 10 and 11 have no effect on legality or on the stored settings.
- R7: When bit 9 is 0, `writeBurstLen` equals the new `readBurstLen`. When bit 9 is 1, `writeBurstLen` is 1.
- R8: A command presented while `banksIdle` is low changes no setting, even if the word is legal.
- R9: `rejectPulse` is high in the cycle after each refused command, whether the word was illegal or a bank was busy. It is low after accepted commands and after cycles without a command.
- R10: While `cmdValid` is low, the address word has no effect on the settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Mode-set command accepted this cycle |
| banksIdle | input | 1 | Both banks are precharged |
| addrWord | input | 12 | Address bus carrying the mode word |
| casLatency | output | 2 | Stored CAS latency (1 to 3) |
| burstInterleave | output | 1 | 0 sequential, 1 interleaved |
| readBurstLen | output | 4 | Read burst length in beats |
| writeBurstLen | output | 4 | Write burst length in beats |
| rejectPulse | output | 1 | One-cycle flag for a refused command |

## Verification
The assertions assume that `banksIdle` and `addrWord` are valid in every cycle in which `cmdValid` is high. They also assume that no X values reach the inputs once reset is released. The bench meets these assumptions by driving every input on the falling edge from a single task, so the inputs are always defined and stable around the rising edge. Its commands cover each illegal field on its own, a busy bank paired with a legal word, legal words with the top bits set, and a legal word presented with no command.

// File: rtl/mode_guard_pkg.sv
package mode_guard_pkg;

  localparam int CL_W  = 2;
  localparam int LEN_W = 4;

  typedef struct packed {
    logic load;
    logic reject;
  } strobe_t;

  typedef struct packed {
    logic [CL_W-1:0]  cl;
    logic             interleave;
    logic [LEN_W-1:0] rdLen;
    logic [LEN_W-1:0] wrLen;
  } mode_t;

endpackage

// File: rtl/mode_guard_ctrl.sv
module mode_guard_ctrl
  import mode_guard_pkg::*;
(
  input  logic    cmdValid,
  input  logic    banksIdle,
  input  logic    wordLegal,
  output strobe_t strobes
);

  logic acceptOk;

  always_comb begin
    acceptOk       = banksIdle && wordLegal;
    strobes.load   = cmdValid && acceptOk;
    strobes.reject = cmdValid && !acceptOk;
  end

endmodule

// File: rtl/mode_guard_dp.sv
module mode_guard_dp
  import mode_guard_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int RESET_CL = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrWord,
  input  strobe_t           strobes,
  output logic              wordLegal,
  output mode_t             mode,
  output logic              rejectPulse
);

  localparam int LEN_LO = 0;
  localparam int TYPE_B = 3;
  localparam int CL_LO  = 4;
  localparam int RSV_LO = 7;
  localparam int WSEL_B = 9;

  logic [2:0] lenCode;
  logic [2:0] clCode;
  logic [1:0] rsvBits;
  logic       lenOk;
  logic       clOk;
  logic       rsvOk;
  mode_t      nextMode;
  mode_t      resetMode;

  always_comb begin
    lenCode   = addrWord[LEN_LO +: 3];
    clCode    = addrWord[CL_LO +: 3];
    rsvBits   = addrWord[RSV_LO +: 2];
    lenOk     = (lenCode[2] == 1'b0);
    clOk      = (clCode[2] == 1'b0) && (clCode[1:0] != 2'b00);
    rsvOk     = (rsvBits == 2'b00);
    wordLegal = lenOk && clOk && rsvOk;

    nextMode.cl         = clCode[CL_W-1:0];
    nextMode.interleave = addrWord[TYPE_B];
    nextMode.rdLen      = LEN_W'(1) << lenCode[1:0];
    nextMode.wrLen      = addrWord[WSEL_B] ? LEN_W'(1) : nextMode.rdLen;

    resetMode.cl         = CL_W'(RESET_CL);
    resetMode.interleave = 1'b0;
    resetMode.rdLen      = LEN_W'(1);
    resetMode.wrLen      = LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode        <= resetMode;
      rejectPulse <= 1'b0;
    end else begin
      rejectPulse <= strobes.reject;
      if (strobes.load) begin
        mode <= nextMode;
      end
    end
  end

  // R7: the stored write length is one beat or the stored read length
  a_r7_wr_len_shape: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(mode.wrLen) && (mode.wrLen == 1 || mode.wrLen == mode.rdLen));

  // R2: the stored latency never reaches the illegal zero code
  a_r2_cl_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    mode.cl != '0);

endmodule

// File: rtl/sdram_mode_guard.sv
module sdram_mode_guard
  import mode_guard_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int RESET_CL = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              banksIdle,
  input  logic [ADDR_W-1:0] addrWord,
  output logic [CL_W-1:0]   casLatency,
  output logic              burstInterleave,
  output logic [LEN_W-1:0]  readBurstLen,
  output logic [LEN_W-1:0]  writeBurstLen,
  output logic              rejectPulse
);

  strobe_t strobes;
  logic    wordLegal;
  mode_t   mode;

  mode_guard_ctrl u_ctrl (
    .cmdValid (cmdValid),
    .banksIdle(banksIdle),
    .wordLegal(wordLegal),
    .strobes  (strobes)
  );

  mode_guard_dp #(
    .ADDR_W  (ADDR_W),
    .RESET_CL(RESET_CL)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .addrWord   (addrWord),
    .strobes    (strobes),
    .wordLegal  (wordLegal),
    .mode       (mode),
    .rejectPulse(rejectPulse)
  );

  assign casLatency      = mode.cl;
  assign burstInterleave = mode.interleave;
  assign readBurstLen    = mode.rdLen;
  assign writeBurstLen   = mode.wrLen;

  logic [CL_W+1+2*LEN_W-1:0] cfgView;
  assign cfgView = {casLatency, burstInterleave, readBurstLen, writeBurstLen};

  // R10: no command, no change
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> $stable(cfgView) && !rejectPulse);

  // R8: busy banks block the update and produce a reject
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !banksIdle |=> $stable(cfgView) && rejectPulse);

  // R3: bad burst length code keeps the settings
  a_r3_bad_len_hold: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && addrWord[2] |=> $stable(cfgView) && rejectPulse);

  // R4: bad latency code keeps the settings
  a_r4_bad_cl_hold: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (addrWord[6] || addrWord[5:4] == 2'b00) |=> $stable(cfgView) && rejectPulse);

  // R5: reserved bits set keep the settings
  a_r5_rsv_hold: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (addrWord[8:7] != 2'b00) |=> $stable(cfgView) && rejectPulse);

  // R9: a reject always traces back to a command one cycle earlier
  a_r9_reject_cause: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !rejectPulse);

endmodule

// File: tb/sdram_mode_guard_tb.sv
module sdram_mode_guard_tb;

  typedef struct {
    logic [1:0] cl;
    logic       il;
    logic [3:0] rd;
    logic [3:0] wr;
    logic       rej;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        banksIdle = 1'b1;
  logic [11:0] addrWord = '0;
  logic [1:0]  casLatency;
  logic        burstInterleave;
  logic [3:0]  readBurstLen;
  logic [3:0]  writeBurstLen;
  logic        rejectPulse;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  exp_t q[$];

  logic [1:0] mCl = 2'd3;
  logic       mIl = 1'b0;
  logic [3:0] mRd = 4'd1;
  logic [3:0] mWr = 4'd1;

  always #10 clk = ~clk;

  sdram_mode_guard u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .banksIdle(banksIdle),
    .addrWord(addrWord), .casLatency(casLatency), .burstInterleave(burstInterleave),
    .readBurstLen(readBurstLen), .writeBurstLen(writeBurstLen), .rejectPulse(rejectPulse)
  );

  function automatic bit specLegal(input logic [11:0] w);
    return (w[2] == 1'b0) && (w[6:4] inside {3'd1, 3'd2, 3'd3}) && (w[8:7] == 2'b00);
  endfunction

  task automatic compare(input exp_t e);
    checks++;
    if (casLatency !== e.cl || burstInterleave !== e.il || readBurstLen !== e.rd ||
        writeBurstLen !== e.wr || rejectPulse !== e.rej) begin
      fails++;
      $display("FAIL %s: got cl=%0d il=%0d rd=%0d wr=%0d rej=%0d, expected cl=%0d il=%0d rd=%0d wr=%0d rej=%0d",
               e.tag, casLatency, burstInterleave, readBurstLen, writeBurstLen, rejectPulse,
               e.cl, e.il, e.rd, e.wr, e.rej);
    end
  endtask

  task automatic drive(input logic cmd, input logic idle, input logic [11:0] w, input string tag);
    exp_t e;
    bit acc;
    @(negedge clk);
    cmdValid  = cmd;
    banksIdle = idle;
    addrWord  = w;
    acc = cmd && idle && specLegal(w);
    if (acc) begin
      mCl = w[5:4];
      mIl = w[3];
      mRd = 4'd1 << w[1:0];
      mWr = w[9] ? 4'd1 : (4'd1 << w[1:0]);
    end
    e.cl = mCl; e.il = mIl; e.rd = mRd; e.wr = mWr;
    e.rej = cmd && !acc;
    e.tag = tag;
    @(posedge clk);
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    exp_t r;
    repeat (3) @(negedge clk);
    r.cl = 2'd3; r.il = 1'b0; r.rd = 4'd1; r.wr = 4'd1; r.rej = 1'b0; r.tag = "R1 reset";
    compare(r);
    rstN = 1'b1;
    @(negedge clk);
    r.tag = "R1 after release";
    compare(r);

    // R2 / R7 legal words
    drive(1, 1, 12'b00_0_00_001_0_001, "R2 cl1 len2 seq");
    drive(1, 1, 12'b00_0_00_010_1_011, "R2 cl2 len8 interleaved");
    drive(1, 1, 12'b00_1_00_011_0_010, "R7 single-beat write");
    drive(1, 1, 12'b00_0_00_011_0_010, "R7 write follows read");
    // R3 illegal length codes
    drive(1, 1, 12'b00_0_00_001_1_100, "R3 length code 4");
    drive(1, 1, 12'b00_0_00_001_1_111, "R3 length code 7");
    // R4 illegal latency codes
    drive(1, 1, 12'b00_0_00_000_0_001, "R4 latency code 0");
    drive(1, 1, 12'b00_0_00_100_0_001, "R4 latency code 4");
    drive(1, 1, 12'b00_0_00_111_0_001, "R4 latency code 7");
    // R5 reserved bits
    drive(1, 1, 12'b00_0_01_001_0_001, "R5 bit7 set");
    drive(1, 1, 12'b00_0_10_001_0_001, "R5 bit8 set");
    // R8 busy banks with legal word
    drive(1, 0, 12'b00_0_00_001_1_000, "R8 busy banks");
    // R6 ignored top bits
    drive(1, 1, 12'b11_0_00_010_1_000, "R6 top bits set len1");
    drive(1, 1, 12'b10_1_00_001_0_011, "R6 bit11 set");
    // R10 no command
    drive(0, 1, 12'b00_0_00_010_1_001, "R10 no command");
    drive(0, 0, 12'b11_1_11_111_1_111, "R10 no command garbage");
    // R9 back to back rejects then accept
    drive(1, 1, 12'b00_0_00_000_0_000, "R9 reject a");
    drive(1, 0, 12'b00_0_00_010_0_001, "R9 reject b");
    drive(1, 1, 12'b00_0_00_010_0_001, "R9 accept clears pulse");
    drive(0, 1, 12'b0, "R9 quiet");

    @(negedge clk);
    cmdValid = 1'b0;
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule